// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block is the software-visible register bank of an asynchronous serial port that has a receive FIFO. A simple single-cycle bus reaches it through a byte offset, a write strobe, a read strobe and write data. Read data comes back registered one clock later. The bank stores the mode, bit-rate, control, FIFO-control and port settings. It keeps five status flags (transmit end, transmit empty, break, receive full, data ready), drives the transmit and receive interrupt lines, and hands a transmit byte to the serializer on a one-cycle strobe.

The receive path lives outside the block. It reports flag-set events on three inputs and exposes its FIFO head byte and fill count. The bank pops that FIFO when software reads the receive data offset. The serializer is modelled as instantaneous: any status read taken while the transmitter is enabled sets the transmit flags again once the read completes.

Top module: `serial_regbank`

## Requirements
- R1: After a synchronous reset, mode, FIFO control and port read 0, control reads 0x20 and the bit-rate output is 0xFF. Status reads 0x60 (transmit end and transmit empty set), and both interrupt lines and the transmit strobe are low.
- R2: The bus byte offsets are mode 0x00, bit rate 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, receive count 0x1C, port 0x20 and line status 0x24. Each register stores the written value through a fixed mask: mode ANDed with 0x7B, control with 0xFA, port with 0xF3, and FIFO control all 16 bits. Each register reads back its stored value.
- R3: A status read returns transmit end at bit 6, transmit empty at bit 5, break at bit 4, receive full at bit 1 and data ready at bit 0, with every other bit 0.
- R4: A status write clears each of the five flags whose bit is 0 and keeps each flag whose bit is 1. The data-ready, receive-full and break event inputs set their flags. An event in the same cycle as a clearing write wins.
- R5: A control write with bit 5 (transmit enable) at 0 sets transmit end. The transmit interrupt output follows stored control bit 7 from the clock after the write.
- R6: The receive interrupt rises on a receive-full event while control bit 6 is set. It falls after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0. A status write with both of those bits at 1 leaves it unchanged.
- R7: A write to transmit data drives its low byte on the byte output with a strobe high for exactly one clock, and it clears transmit empty.
- R8: A status read returns the flags as they stood before the read. If control bit 5 is set, transmit empty and transmit end are set after the read. If control bit 5 is clear, they are left unchanged.
- R9: A receive data read with a nonzero FIFO count returns the FIFO head byte and pulses the pop output for one clock. It clears receive full when the count minus one is below the trigger level. The trigger level is taken from FIFO control bits 7:6 (0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14). With a count of 0 the read returns 0 and does not pop. A receive count read returns the FIFO count.
- R10: Writes to bit rate are stored and appear on the bit-rate output. Reads of bit rate, transmit data, line status, unaligned offsets and offsets from 0x28 up return 0.
- R11: Read data appears on the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tx_byte | output | 8 | Byte handed to the serializer |
| tx_strobe | output | 1 | One-cycle pulse marking a new transmit byte |
| baud_div | output | 8 | Stored bit-rate value |
| rx_trig_level | output | 4 | Receive trigger level decoded from FIFO control |
| rx_dr_set | input | 1 | Receive path event: set data ready |
| rx_full_set | input | 1 | Receive path event: set receive full |
| rx_break_set | input | 1 | Receive path event: set break |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | One-cycle pop request to the receive FIFO |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
A wrong flag state shows on the next status read, one clock after the strobe. A flag that is cleared or set by a stale side effect also shows through the value returned by the following read, because that read reports the pre-read state. The bench therefore always reads status twice around a side effect. Wrong interrupt state is visible on the interrupt pins in the first cycle after the event or write that should have changed it. A wrong pop decision appears on the pop pin and on the receive-full bit in the same clock as the read data.

// File: rtl/serial_regbank_pkg.sv
package serial_regbank_pkg;

  // Byte offsets of the register slots
  localparam logic [7:0] OFS_MODE = 8'h00;
  localparam logic [7:0] OFS_BAUD = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h08;
  localparam logic [7:0] OFS_TXD  = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_RXD  = 8'h14;
  localparam logic [7:0] OFS_FCR  = 8'h18;
  localparam logic [7:0] OFS_RCNT = 8'h1C;
  localparam logic [7:0] OFS_PORT = 8'h20;
  localparam logic [7:0] OFS_LSR  = 8'h24;

  // Storage masks
  localparam logic [7:0] MODE_MASK = 8'h7B;
  localparam logic [7:0] CTL_MASK  = 8'hFA;
  localparam logic [7:0] PORT_MASK = 8'hF3;

  // Reset values
  localparam logic [7:0] BAUD_RST = 8'hFF;
  localparam logic [7:0] CTL_RST  = 8'h20;

  // Control bit positions
  localparam int CTL_TIE = 7;
  localparam int CTL_RIE = 6;
  localparam int CTL_TE  = 5;

  // Status bit positions
  localparam int ST_TEND = 6;
  localparam int ST_TDE  = 5;
  localparam int ST_BRK  = 4;
  localparam int ST_RDF  = 1;
  localparam int ST_DR   = 0;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } flags_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_BAUD, SEL_CTL, SEL_TXD, SEL_STAT,
    SEL_RXD, SEL_FCR, SEL_RCNT, SEL_PORT, SEL_LSR
  } sel_e;

  function automatic logic [3:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    trig_level = 4'd1;
      2'd1:    trig_level = 4'd4;
      2'd2:    trig_level = 4'd8;
      default: trig_level = 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/sr_decode.sv
module sr_decode
  import serial_regbank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  logic [7:0] a8;

  always_comb begin
    a8 = 8'(addr);
    case (a8)
      OFS_MODE: sel = SEL_MODE;
      OFS_BAUD: sel = SEL_BAUD;
      OFS_CTL:  sel = SEL_CTL;
      OFS_TXD:  sel = SEL_TXD;
      OFS_STAT: sel = SEL_STAT;
      OFS_RXD:  sel = SEL_RXD;
      OFS_FCR:  sel = SEL_FCR;
      OFS_RCNT: sel = SEL_RCNT;
      OFS_PORT: sel = SEL_PORT;
      OFS_LSR:  sel = SEL_LSR;
      default:  sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/sr_cfg.sv
module sr_cfg
  import serial_regbank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        mode_q,
  output logic [7:0]        baud_q,
  output logic [7:0]        ctl_q,
  output logic [DATA_W-1:0] fcr_q,
  output logic [7:0]        port_q,
  output logic [7:0]        tx_byte,
  output logic              tx_strobe
);
  logic [7:0] wbyte;
  assign wbyte = wdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      baud_q    <= BAUD_RST;
      ctl_q     <= CTL_RST;
      fcr_q     <= '0;
      port_q    <= '0;
      tx_byte   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= 1'b0;
      if (wr) begin
        case (sel)
          SEL_MODE: mode_q <= wbyte & MODE_MASK;
          SEL_BAUD: baud_q <= wbyte;
          SEL_CTL:  ctl_q  <= wbyte & CTL_MASK;
          SEL_FCR:  fcr_q  <= wdata;
          SEL_PORT: port_q <= wbyte & PORT_MASK;
          SEL_TXD: begin
            tx_byte   <= wbyte;
            tx_strobe <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sr_flags.sv
module sr_flags
  import serial_regbank_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stat_wr,
  input  flags_t stat_keep,
  input  logic   ctl_wr,
  input  logic   ctl_wr_te,
  input  logic   ctl_wr_rie,
  input  logic   txd_wr,
  input  logic   stat_rd,
  input  logic   ctl_te,
  input  logic   ctl_rie,
  input  logic   rxd_pop,
  input  logic   rxd_below,
  input  logic   ev_dr,
  input  logic   ev_full,
  input  logic   ev_brk,
  output flags_t flags_q,
  output logic   irq_rx
);
  flags_t nxt;
  logic   irq_n;

  always_comb begin
    nxt   = flags_q;
    irq_n = irq_rx;
    // Software clears: a zero bit clears, a one bit keeps
    if (stat_wr) begin
      nxt.tend = nxt.tend & stat_keep.tend;
      nxt.tde  = nxt.tde  & stat_keep.tde;
      nxt.brk  = nxt.brk  & stat_keep.brk;
      nxt.rdf  = nxt.rdf  & stat_keep.rdf;
      nxt.dr   = nxt.dr   & stat_keep.dr;
      if (!stat_keep.rdf || !stat_keep.dr) irq_n = 1'b0;
    end
    if (txd_wr) nxt.tde = 1'b0;
    if (ctl_wr) begin
      if (!ctl_wr_te)  nxt.tend = 1'b1;
      if (!ctl_wr_rie) irq_n    = 1'b0;
    end
    // Instant transmitter: a status read refills the transmit flags
    if (stat_rd && ctl_te) begin
      nxt.tde  = 1'b1;
      nxt.tend = 1'b1;
    end
    if (rxd_pop && rxd_below) nxt.rdf = 1'b0;
    // Receive path events have the last word
    if (ev_dr)  nxt.dr  = 1'b1;
    if (ev_brk) nxt.brk = 1'b1;
    if (ev_full) begin
      nxt.rdf = 1'b1;
      if (ctl_rie) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};
      irq_rx  <= 1'b0;
    end else begin
      flags_q <= nxt;
      irq_rx  <= irq_n;
    end
  end
endmodule

// File: rtl/sr_rdmux.sv
module sr_rdmux
  import serial_regbank_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  sel_e              sel,
  input  flags_t            flags,
  input  logic [7:0]        mode_q,
  input  logic [7:0]        ctl_q,
  input  logic [DATA_W-1:0] fcr_q,
  input  logic [7:0]        port_q,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [7:0]        rx_data,
  input  logic              rxd_pop,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_pop
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    case (sel)
      SEL_MODE: word = DATA_W'(mode_q);
      SEL_CTL:  word = DATA_W'(ctl_q);
      SEL_FCR:  word = fcr_q;
      SEL_PORT: word = DATA_W'(port_q);
      SEL_RCNT: word = DATA_W'(rx_count);
      SEL_RXD:  word = rxd_pop ? DATA_W'(rx_data) : '0;
      SEL_STAT: begin
        word[ST_TEND] = flags.tend;
        word[ST_TDE]  = flags.tde;
        word[ST_BRK]  = flags.brk;
        word[ST_RDF]  = flags.rdf;
        word[ST_DR]   = flags.dr;
      end
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rx_pop <= 1'b0;
    end else begin
      rx_pop <= rxd_pop;
      if (rd) rdata <= word;
    end
  end
endmodule

// File: rtl/serial_regbank.sv
module serial_regbank
  import serial_regbank_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [7:0]        tx_byte,
  output logic              tx_strobe,
  output logic [7:0]        baud_div,
  output logic [3:0]        rx_trig_level,
  input  logic              rx_dr_set,
  input  logic              rx_full_set,
  input  logic              rx_break_set,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  output logic              irq_tx,
  output logic              irq_rx
);
  sel_e              sel;
  logic [7:0]        mode_q, ctl_q, port_q;
  logic [DATA_W-1:0] fcr_q;
  flags_t            flags_q;
  flags_t            stat_keep;
  logic              rxd_pop, rxd_below;
  logic [7:0]        cnt8, trig8;

  sr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  sr_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .mode_q(mode_q), .baud_q(baud_div), .ctl_q(ctl_q), .fcr_q(fcr_q),
    .port_q(port_q), .tx_byte(tx_byte), .tx_strobe(tx_strobe)
  );

  assign rx_trig_level = trig_level(fcr_q[7:6]);
  assign cnt8          = 8'(rx_count);
  assign trig8         = 8'(rx_trig_level);
  assign rxd_pop       = bus_rd && (sel == SEL_RXD) && (rx_count != '0);
  // count - 1 < trigger  <=>  count <= trigger
  assign rxd_below     = (cnt8 <= trig8);
  assign irq_tx        = ctl_q[CTL_TIE];

  assign stat_keep = '{tend: bus_wdata[ST_TEND], tde: bus_wdata[ST_TDE],
                       brk:  bus_wdata[ST_BRK],  rdf: bus_wdata[ST_RDF],
                       dr:   bus_wdata[ST_DR]};

  sr_flags u_flags (
    .clk(clk), .rst(rst),
    .stat_wr(bus_wr && sel == SEL_STAT), .stat_keep(stat_keep),
    .ctl_wr(bus_wr && sel == SEL_CTL),
    .ctl_wr_te(bus_wdata[CTL_TE]), .ctl_wr_rie(bus_wdata[CTL_RIE]),
    .txd_wr(bus_wr && sel == SEL_TXD),
    .stat_rd(bus_rd && sel == SEL_STAT),
    .ctl_te(ctl_q[CTL_TE]), .ctl_rie(ctl_q[CTL_RIE]),
    .rxd_pop(rxd_pop), .rxd_below(rxd_below),
    .ev_dr(rx_dr_set), .ev_full(rx_full_set), .ev_brk(rx_break_set),
    .flags_q(flags_q), .irq_rx(irq_rx)
  );

  sr_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel(sel), .flags(flags_q),
    .mode_q(mode_q), .ctl_q(ctl_q), .fcr_q(fcr_q), .port_q(port_q),
    .rx_count(rx_count), .rx_data(rx_data), .rxd_pop(rxd_pop),
    .rdata(bus_rdata), .rx_pop(rx_pop)
  );
endmodule

// File: rtl/serial_regbank_chk.sv
module serial_regbank_chk
  import serial_regbank_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [7:0]        tx_byte,
  input logic              tx_strobe,
  input logic              rx_full_set,
  input logic              rx_break_set,
  input logic [CNT_W-1:0]  rx_count,
  input logic              rx_pop,
  input logic              irq_tx,
  input logic              irq_rx,
  input flags_t            flags
);
  localparam logic [DATA_W-1:0] STAT_BITS = DATA_W'(16'h0073);

  p_tx_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && 8'(bus_addr) == OFS_TXD) |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));

  p_tde_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && 8'(bus_addr) == OFS_TXD) |=> !flags.tde);

  p_irq_tx_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && 8'(bus_addr) == OFS_CTL) |=> (irq_tx == $past(bus_wdata[7])));

  p_tend_set_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && 8'(bus_addr) == OFS_CTL && !bus_wdata[5]) |=> flags.tend);

  p_irq_rx_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && 8'(bus_addr) == OFS_STAT && bus_wdata[1:0] != 2'b11 && !rx_full_set)
    |=> !irq_rx);

  p_pop_cause_r9: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> $past(bus_rd && 8'(bus_addr) == OFS_RXD && rx_count != '0));

  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && 8'(bus_addr) >= 8'h28) |=> (bus_rdata == '0));

  p_stat_layout_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && 8'(bus_addr) == OFS_STAT) |=> ((bus_rdata & ~STAT_BITS) == '0));

  p_break_wins_r4: assert property (@(posedge clk) disable iff (rst)
    rx_break_set |=> flags.brk);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind serial_regbank serial_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_byte(tx_byte),
  .tx_strobe(tx_strobe), .rx_full_set(rx_full_set), .rx_break_set(rx_break_set),
  .rx_count(rx_count), .rx_pop(rx_pop), .irq_tx(irq_tx), .irq_rx(irq_rx),
  .flags(flags_q)
);

// File: tb/serial_regbank_bench.sv
`timescale 1ns/1ps
module serial_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  tx_byte, baud_div;
  logic        tx_strobe;
  logic [3:0]  rx_trig_level;
  logic        rx_dr_set = 1'b0, rx_full_set = 1'b0, rx_break_set = 1'b0;
  logic [4:0]  rx_count = '0;
  logic [7:0]  rx_data = 8'hA5;
  logic        rx_pop, irq_tx, irq_rx;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_regbank u_serial_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_byte(tx_byte),
    .tx_strobe(tx_strobe), .baud_div(baud_div), .rx_trig_level(rx_trig_level),
    .rx_dr_set(rx_dr_set), .rx_full_set(rx_full_set), .rx_break_set(rx_break_set),
    .rx_count(rx_count), .rx_data(rx_data), .rx_pop(rx_pop),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d, output logic p);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; p = rx_pop;
  endtask

  task automatic ev(input logic d, input logic f, input logic b);
    @(negedge clk);
    rx_dr_set = d; rx_full_set = f; rx_break_set = b;
    @(negedge clk);
    rx_dr_set = 1'b0; rx_full_set = 1'b0; rx_break_set = 1'b0;
  endtask

  function automatic logic [15:0] smap(input int p);
    logic [15:0] v = '0;
    v[6] = p[4]; v[5] = p[3]; v[4] = p[2]; v[1] = p[1]; v[0] = p[0];
    return v;
  endfunction

  function automatic int trig(input int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d, d2;
    logic p;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    @(negedge clk);
    chk(baud_div == 8'hFF, "R1 baud", baud_div, 'hFF);
    chk(!irq_tx && !irq_rx && !tx_strobe, "R1 outputs low", {irq_tx, irq_rx, tx_strobe}, 0);
    rd(6'h00, d, p); chk(d == 0, "R1 mode", d, 0);
    rd(6'h08, d, p); chk(d == 16'h20, "R1 control", d, 'h20);
    rd(6'h18, d, p); chk(d == 0, "R1 fifo ctl", d, 0);
    rd(6'h20, d, p); chk(d == 0, "R1 port", d, 0);
    rd(6'h10, d, p); chk(d == 16'h60, "R1 status", d, 'h60);

    // R2 masks
    for (int v = 0; v < 256; v++) begin
      wr(6'h00, 16'(v)); rd(6'h00, d, p);
      chk(d == 16'(v & 'h7B), "R2 mode mask", d, v & 'h7B);
      wr(6'h20, 16'(v)); rd(6'h20, d, p);
      chk(d == 16'(v & 'hF3), "R2 port mask", d, v & 'hF3);
      wr(6'h08, 16'(v)); rd(6'h08, d, p);
      chk(d == 16'(v & 'hFA), "R2 control mask", d, v & 'hFA);
      chk(irq_tx == v[7], "R5 irq_tx follows bit 7", irq_tx, v[7]);
    end
    wr(6'h18, 16'hBEEF); rd(6'h18, d, p); chk(d == 16'hBEEF, "R2 fifo ctl", d, 'hBEEF);
    wr(6'h18, 16'h0000);
    wr(6'h08, 16'h20);

    // R5 / R8: transmit end set by control write, no refill with enable clear
    wr(6'h10, 16'h0000);
    wr(6'h08, 16'h00);
    rd(6'h10, d, p);  chk(d == 16'h40, "R5 tend set by ctl write", d, 'h40);
    rd(6'h10, d2, p); chk(d2 == 16'h40, "R8 no refill when disabled", d2, 'h40);
    wr(6'h08, 16'h20);

    // R3 / R4 status write sweep
    for (int pt = 0; pt < 32; pt++) begin
      ev(1'b1, 1'b1, 1'b1);
      rd(6'h10, d, p);
      rd(6'h10, d, p);
      chk(d == 16'h73, "R3 all flags", d, 'h73);
      wr(6'h10, smap(pt) | 16'hFF8C);
      rd(6'h10, d, p);
      chk(d == smap(pt), "R4 clear by zero", d, smap(pt));
    end

    // R4 event wins against same-cycle clear
    @(negedge clk);
    bus_addr = 6'h10; bus_wdata = 16'h0000; bus_wr = 1'b1; rx_break_set = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rx_break_set = 1'b0;
    rd(6'h10, d, p); chk(d == 16'h10, "R4 break wins", d, 'h10);

    // R6 receive interrupt
    wr(6'h08, 16'h60);
    ev(1'b0, 1'b1, 1'b0); chk(irq_rx == 1, "R6 irq on full", irq_rx, 1);
    wr(6'h10, 16'hFFFF);  chk(irq_rx == 1, "R6 irq kept", irq_rx, 1);
    wr(6'h10, 16'hFFFE);  chk(irq_rx == 0, "R6 irq cleared by dr bit", irq_rx, 0);
    ev(1'b0, 1'b1, 1'b0);
    wr(6'h10, 16'hFFFD);  chk(irq_rx == 0, "R6 irq cleared by rdf bit", irq_rx, 0);
    ev(1'b0, 1'b1, 1'b0);
    wr(6'h08, 16'h20);    chk(irq_rx == 0, "R6 irq cleared by ctl", irq_rx, 0);
    ev(1'b0, 1'b1, 1'b0); chk(irq_rx == 0, "R6 irq gated", irq_rx, 0);

    // R7 / R8 transmit
    wr(6'h0C, 16'h335A);
    chk(tx_strobe == 1 && tx_byte == 8'h5A, "R7 strobe and byte", {tx_strobe, tx_byte}, 'h15A);
    @(negedge clk); chk(tx_strobe == 0, "R7 strobe one cycle", tx_strobe, 0);
    rd(6'h10, d, p);  chk(d[5] == 0, "R8 pre-read tde", d[5], 0);
    rd(6'h10, d2, p); chk(d2[6:5] == 2'b11, "R8 refill after read", d2[6:5], 3);

    // R9 receive data pops and trigger sweep
    rx_count = 5'd0;
    rd(6'h14, d, p); chk(d == 0 && p == 0, "R9 empty read", {p, d}, 0);
    for (int c = 0; c < 4; c++) begin
      wr(6'h18, 16'(c << 6));
      chk(int'(rx_trig_level) == trig(c), "R9 trigger level", rx_trig_level, trig(c));
      for (int n = 1; n <= 16; n++) begin
        rx_count = 5'(n);
        rx_data  = 8'(n * 13 + c);
        ev(1'b0, 1'b1, 1'b0);
        rd(6'h1C, d, p); chk(d == 16'(n), "R9 count read", d, n);
        rd(6'h14, d, p);
        chk(d == 16'(n * 13 + c) && p == 1, "R9 data and pop", {p, d}, 'h10000 | ((n * 13 + c) & 'hFF));
        rd(6'h10, d, p);
        chk(d[1] == !((n - 1) < trig(c)), "R9 rdf after pop", d[1], !((n - 1) < trig(c)));
      end
    end
    rx_count = 5'd0;
    wr(6'h18, 16'h0000);

    // R10 unimplemented and bit rate
    wr(6'h04, 16'h0037); chk(baud_div == 8'h37, "R10 baud stored", baud_div, 'h37);
    wr(6'h24, 16'hFFFF);
    rd(6'h04, d, p); chk(d == 0, "R10 baud reads 0", d, 0);
    rd(6'h0C, d, p); chk(d == 0, "R10 txd reads 0", d, 0);
    rd(6'h24, d, p); chk(d == 0, "R10 line status 0", d, 0);
    rd(6'h01, d, p); chk(d == 0, "R10 unaligned 0", d, 0);
    for (int a = 'h28; a < 64; a++) begin
      rd(6'(a), d, p); chk(d == 0, "R10 high offset 0", d, 0);
    end

    // R11 hold
    rd(6'h08, d, p);
    repeat (4) @(negedge clk);
    chk(bus_rdata == 16'h20, "R11 read data held", bus_rdata, 'h20);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule